// File: doc/BRIEF.md
# Machine Cycle Bus Strobe Sequencer

This block produces the timing skeleton of a classic 8-bit controller machine cycle. It divides the oscillator clock into six states with two phases each, so that one machine cycle spans twelve oscillator periods. From the current state and phase it generates the two code-fetch enables of each cycle and a program-counter advance pulse. For the external program-memory bus it also generates the address latch strobe, the active-low program read strobe, and the drive enables for the low and high address ports.

Fetches run twice in every machine cycle, even when the instruction being executed does not need the extra code byte. The only exception is the second cycle of the two-cycle external data-move instruction. In that cycle the bus carries data, so fetches, the PC advance, the address latch strobe and new program read pulses are all withheld. The address latch strobe keeps running while code comes from internal memory, so it can serve as a clock output. In that mode the program read strobe and the address drive enables stay idle.

The decoder drives `xfer_instr` to flag the data-move instruction. `ext_pmem_sel` chooses external program memory. Both inputs are sampled once per machine cycle, on its final tick.

Top module: `mc_strobe_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer returns to state 0, phase 0 (S1P1). The outputs then read `ale`=0, `psen_n`=1, `p0_addr_en`=0 and `p2_addr_en`=0, and that S1P1 carries no program read pulse.
- R2: `state_idx` counts 0 to 5 for S1 to S6 and `phase_idx` counts 0 to 1 for P1 to P2. They advance one phase per clock and wrap from S6P2 to S1P1, giving 12 clocks per machine cycle.
- R3: In a fetching cycle, `op_latch_en` is high only during S1P1 and `fetch2_en` only during S4P1. `pc_inc` is high in exactly those two ticks, so the PC advances twice per machine cycle whether or not the code byte is used.
- R4: In a fetching cycle, `ale` is high from S1P2 through S2P1 and from S4P2 through S5P1. That is two pulses of two ticks each, in both internal and external program-memory mode.
- R5: In external mode, `psen_n` is low from S3P1 through S4P1 and from S6P1 through S1P1 of the following cycle. That is two falling edges per fetching cycle.
- R6: In internal mode, `psen_n` stays high and both address drive enables stay low. The one exception is S1P1 directly after an external cycle, where that cycle's last read pulse completes.
- R7: In external mode, `p0_addr_en` is high exactly while `ale` is high. `p2_addr_en` is high from S1P2 through S4P1 and from S4P2 through S1P1 of the following cycle.
- R8: If `xfer_instr` is high on the S6P2 tick of a fetching cycle, the next machine cycle is a data-move cycle. In that cycle `op_latch_en`, `fetch2_en`, `pc_inc`, `ale` and `p0_addr_en` stay low for all twelve ticks. `psen_n` and `p2_addr_en` are active only in its S1P1, which finishes the previous cycle's read.
- R9: `xfer_instr` has no effect on any tick other than S6P2. It also has no effect on the S6P2 of a data-move cycle, so two data-move cycles never run back to back.
- R10: `ext_pmem_sel` is sampled during reset and on each S6P2. A change in the middle of a cycle takes effect from the next S1P1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst | input | 1 | Synchronous reset, active high |
| ext_pmem_sel | input | 1 | 1 = program memory is external |
| xfer_instr | input | 1 | Decoder flag: current instruction is the external data move |
| state_idx | output | 3 | Current state, 0..5 for S1..S6 |
| phase_idx | output | 1 | Current phase, 0 = P1, 1 = P2 |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| p0_addr_en | output | 1 | Drive low address byte on port 0 |
| p2_addr_en | output | 1 | Drive high address byte on port 2 |
| op_latch_en | output | 1 | Latch opcode into instruction register (S1P1) |
| fetch2_en | output | 1 | Second code-byte fetch (S4P1) |
| pc_inc | output | 1 | Program counter advance pulse |

## Verification
The checker takes it for granted that `rst` is held for at least one edge before any property is judged. It also assumes the mode and data-move inputs are only looked at on the machine-cycle boundary. Its quiet-bus rule for internal mode therefore excuses the S1P1 tick, where a read pulse left over from a preceding external cycle may still be completing. The bench respects these assumptions. It changes `xfer_instr` and `ext_pmem_sel` only on falling clock edges. It releases reset exactly on an S1P1 tick. It flips the mode in the middle of a cycle only to show that the change waits for the next boundary.

// File: rtl/mss_pkg.sv
package mss_pkg;

   localparam int MAX_TICKS = 64;
   localparam int MW        = 6;

   typedef struct packed {
      logic ale;
      logic psen;
      logic p0;
      logic p2;
   } bus_strb_t;

   // Set bits [start, start+len) of a tick mask. The bits that fall inside
   // the current cycle are returned when wrap=0; the bits that spill into
   // the next cycle, folded back to that cycle's ticks, are returned when wrap=1.
   function automatic logic [MAX_TICKS-1:0] win_mask(int cyc, int start, int len, bit wrap);
      logic [MAX_TICKS-1:0] m;
      m = '0;
      for (int i = 0; i < len; i++) begin
         int p;
         p = start + i;
         if (!wrap && p < cyc)
            m[MW'(p)] = 1'b1;
         else if (wrap && p >= cyc && (p - cyc) < cyc)
            m[MW'(p - cyc)] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/mss_tick_counter.sv
module mss_tick_counter #(
   parameter int NUM_STATES = 6,
   parameter int PHASES     = 2,
   localparam int CYC = NUM_STATES * PHASES,
   localparam int SW  = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1,
   localparam int PW  = (PHASES > 1) ? $clog2(PHASES) : 1,
   localparam int TW  = mss_pkg::MW
) (
   input  logic          clk,
   input  logic          rst,
   output logic [SW-1:0] state_q,
   output logic [PW-1:0] phase_q,
   output logic [TW-1:0] tick,
   output logic          cycle_end
);

   logic phase_last;

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= '0;
      else if (phase_last)
         state_q <= (state_q == SW'(NUM_STATES - 1)) ? '0 : state_q + 1'b1;
   end

   generate
      if (PHASES == 1) begin : g_single_phase
         assign phase_q    = '0;
         assign phase_last = 1'b1;
      end else begin : g_multi_phase
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk) begin
            if (rst)
               ph_q <= '0;
            else if (ph_q == PW'(PHASES - 1))
               ph_q <= '0;
            else
               ph_q <= ph_q + 1'b1;
         end
         assign phase_q    = ph_q;
         assign phase_last = (ph_q == PW'(PHASES - 1));
      end
   endgenerate

   assign tick      = TW'(state_q) * TW'(PHASES) + TW'(phase_q);
   assign cycle_end = phase_last && (state_q == SW'(NUM_STATES - 1));

endmodule

// File: rtl/mss_cycle_ctrl.sv
module mss_cycle_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic cycle_end,
   input  logic xfer_instr,
   input  logic ext_pmem_sel,
   output logic fetch_act,
   output logic ext_mode,
   output logic prev_fetch,
   output logic prev_xfetch
);

   logic skip_q;
   logic ext_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         skip_q      <= 1'b0;
         ext_q       <= ext_pmem_sel;
         prev_fetch  <= 1'b0;
         prev_xfetch <= 1'b0;
      end else if (cycle_end) begin
         skip_q      <= xfer_instr & ~skip_q;
         ext_q       <= ext_pmem_sel;
         prev_fetch  <= ~skip_q;
         prev_xfetch <= ~skip_q & ext_q;
      end
   end

   assign fetch_act = ~skip_q;
   assign ext_mode  = ext_q;

endmodule

// File: rtl/mss_strobe_gen.sv
module mss_strobe_gen #(
   parameter int NUM_STATES   = 6,
   parameter int PHASES       = 2,
   parameter int FETCH2_STATE = 4,
   parameter int ALE_LEN      = 2,
   parameter int PSEN_GAP     = 1,
   parameter int PSEN_LEN     = 3,
   localparam int CYC   = NUM_STATES * PHASES,
   localparam int TW    = mss_pkg::MW,
   localparam int SLOTS = 2,
   localparam int SPAN  = ALE_LEN + PSEN_GAP + PSEN_LEN
) (
   input  logic               tick_ok,
   input  logic [TW-1:0]      tick,
   input  logic               fetch_act,
   input  logic               ext_mode,
   input  logic               prev_fetch,
   input  logic               prev_xfetch,
   output mss_pkg::bus_strb_t strb,
   output logic               op_latch_en,
   output logic               fetch2_en,
   output logic               pc_inc
);

   logic [SLOTS-1:0] ale_v, psen_v, p0_v, p2_v, fetch_v;
   logic             cur_x;

   assign cur_x = fetch_act & ext_mode;

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         localparam int BASE = (k == 0) ? 0 : (FETCH2_STATE - 1) * PHASES;
         localparam logic [mss_pkg::MAX_TICKS-1:0] ALE_C = mss_pkg::win_mask(CYC, BASE + 1, ALE_LEN, 1'b0);
         localparam logic [mss_pkg::MAX_TICKS-1:0] ALE_W = mss_pkg::win_mask(CYC, BASE + 1, ALE_LEN, 1'b1);
         localparam logic [mss_pkg::MAX_TICKS-1:0] PS_C  = mss_pkg::win_mask(CYC, BASE + 1 + ALE_LEN + PSEN_GAP, PSEN_LEN, 1'b0);
         localparam logic [mss_pkg::MAX_TICKS-1:0] PS_W  = mss_pkg::win_mask(CYC, BASE + 1 + ALE_LEN + PSEN_GAP, PSEN_LEN, 1'b1);
         localparam logic [mss_pkg::MAX_TICKS-1:0] AD_C  = mss_pkg::win_mask(CYC, BASE + 1, SPAN, 1'b0);
         localparam logic [mss_pkg::MAX_TICKS-1:0] AD_W  = mss_pkg::win_mask(CYC, BASE + 1, SPAN, 1'b1);

         assign ale_v[k]   = tick_ok & ((fetch_act & ALE_C[tick]) | (prev_fetch & ALE_W[tick]));
         assign p0_v[k]    = tick_ok & ((cur_x & ALE_C[tick]) | (prev_xfetch & ALE_W[tick]));
         assign psen_v[k]  = tick_ok & ((cur_x & PS_C[tick]) | (prev_xfetch & PS_W[tick]));
         assign p2_v[k]    = tick_ok & ((cur_x & AD_C[tick]) | (prev_xfetch & AD_W[tick]));
         assign fetch_v[k] = tick_ok & fetch_act & (tick == TW'(BASE));
      end
   endgenerate

   assign strb.ale  = |ale_v;
   assign strb.psen = |psen_v;
   assign strb.p0   = |p0_v;
   assign strb.p2   = |p2_v;

   assign op_latch_en = fetch_v[0];
   assign fetch2_en   = fetch_v[1];
   assign pc_inc      = |fetch_v;

endmodule

// File: rtl/mc_strobe_seq.sv
module mc_strobe_seq #(
   parameter int NUM_STATES   = 6,
   parameter int PHASES       = 2,
   parameter int FETCH2_STATE = 4,
   parameter int ALE_LEN      = 2,
   parameter int PSEN_GAP     = 1,
   parameter int PSEN_LEN     = 3,
   localparam int SW = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1,
   localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ext_pmem_sel,
   input  logic          xfer_instr,
   output logic [SW-1:0] state_idx,
   output logic [PW-1:0] phase_idx,
   output logic          ale,
   output logic          psen_n,
   output logic          p0_addr_en,
   output logic          p2_addr_en,
   output logic          op_latch_en,
   output logic          fetch2_en,
   output logic          pc_inc
);

   localparam int CYC  = NUM_STATES * PHASES;
   localparam int B2   = (FETCH2_STATE - 1) * PHASES;
   localparam int SPAN = ALE_LEN + PSEN_GAP + PSEN_LEN;
   localparam int TW   = mss_pkg::MW;

   generate
      if (NUM_STATES < 2 || PHASES < 1) begin : g_bad_shape
         $error("mc_strobe_seq: need at least two states and one phase");
      end
      if (CYC > mss_pkg::MAX_TICKS) begin : g_bad_len
         $error("mc_strobe_seq: machine cycle longer than tick mask");
      end
      if (FETCH2_STATE < 2 || FETCH2_STATE > NUM_STATES) begin : g_bad_fetch2
         $error("mc_strobe_seq: second fetch state out of range");
      end
      if (ALE_LEN < 1 || PSEN_LEN < 1 || PSEN_GAP < 0) begin : g_bad_win
         $error("mc_strobe_seq: strobe window lengths invalid");
      end
      if (SPAN > B2 || SPAN > CYC - B2) begin : g_overlap
         $error("mc_strobe_seq: fetch bus windows overlap");
      end
   endgenerate

   logic [SW-1:0]      state_q;
   logic [PW-1:0]      phase_q;
   logic [TW-1:0]      tick;
   logic               cycle_end;
   logic               fetch_act;
   logic               ext_mode;
   logic               prev_fetch;
   logic               prev_xfetch;
   mss_pkg::bus_strb_t strb;

   mss_tick_counter #(
      .NUM_STATES(NUM_STATES),
      .PHASES    (PHASES)
   ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .state_q  (state_q),
      .phase_q  (phase_q),
      .tick     (tick),
      .cycle_end(cycle_end)
   );

   mss_cycle_ctrl u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .cycle_end   (cycle_end),
      .xfer_instr  (xfer_instr),
      .ext_pmem_sel(ext_pmem_sel),
      .fetch_act   (fetch_act),
      .ext_mode    (ext_mode),
      .prev_fetch  (prev_fetch),
      .prev_xfetch (prev_xfetch)
   );

   mss_strobe_gen #(
      .NUM_STATES  (NUM_STATES),
      .PHASES      (PHASES),
      .FETCH2_STATE(FETCH2_STATE),
      .ALE_LEN     (ALE_LEN),
      .PSEN_GAP    (PSEN_GAP),
      .PSEN_LEN    (PSEN_LEN)
   ) u_strb (
      .tick_ok    (1'b1),
      .tick       (tick),
      .fetch_act  (fetch_act),
      .ext_mode   (ext_mode),
      .prev_fetch (prev_fetch),
      .prev_xfetch(prev_xfetch),
      .strb       (strb),
      .op_latch_en(op_latch_en),
      .fetch2_en  (fetch2_en),
      .pc_inc     (pc_inc)
   );

   assign state_idx  = state_q;
   assign phase_idx  = phase_q;
   assign ale        = strb.ale;
   assign psen_n     = ~strb.psen;
   assign p0_addr_en = strb.p0;
   assign p2_addr_en = strb.p2;

endmodule

// File: rtl/mss_chk.sv
module mss_chk #(
   parameter int NUM_STATES = 6,
   parameter int PHASES     = 2,
   localparam int SW = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1,
   localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input logic          clk,
   input logic          rst,
   input logic [SW-1:0] state_idx,
   input logic [PW-1:0] phase_idx,
   input logic          ale,
   input logic          psen_n,
   input logic          p0_addr_en,
   input logic          p2_addr_en,
   input logic          op_latch_en,
   input logic          fetch2_en,
   input logic          pc_inc,
   input logic          fetch_act,
   input logic          ext_mode
);

   logic at_start, at_end, ph_last;
   assign at_start = (state_idx == '0) && (phase_idx == '0);
   assign ph_last  = (phase_idx == PW'(PHASES - 1));
   assign at_end   = ph_last && (state_idx == SW'(NUM_STATES - 1));

   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> at_start && !ale && psen_n && !p0_addr_en && !p2_addr_en);

   p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
      !ph_last |=> (phase_idx == PW'($past(phase_idx) + 1'b1)) && $stable(state_idx));

   p_state_step_r2: assert property (@(posedge clk) disable iff (rst)
      ph_last && !at_end |=> (phase_idx == '0) && (state_idx == SW'($past(state_idx) + 1'b1)));

   p_cycle_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      at_end |=> at_start);

   p_fetch_excl_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({op_latch_en, fetch2_en}));

   p_opcode_slot_r3: assert property (@(posedge clk) disable iff (rst)
      op_latch_en |-> at_start);

   p_ale_width_r4: assert property (@(posedge clk) disable iff (rst)
      ale && $past(ale) |=> !ale);

   p_psen_width_r5: assert property (@(posedge clk) disable iff (rst)
      !psen_n && $past(!psen_n) && $past(!psen_n, 2) |=> psen_n);

   p_internal_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !ext_mode && !at_start |-> psen_n && !p0_addr_en && !p2_addr_en);

   p_p0_in_ale_r7: assert property (@(posedge clk) disable iff (rst)
      p0_addr_en |-> ale && p2_addr_en);

   p_skip_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      !fetch_act |-> !ale && !p0_addr_en && !op_latch_en && !fetch2_en && !pc_inc);

   p_no_double_skip_r9: assert property (@(posedge clk) disable iff (rst)
      !fetch_act && at_end |=> fetch_act);

endmodule

bind mc_strobe_seq mss_chk #(
   .NUM_STATES(NUM_STATES),
   .PHASES    (PHASES)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .state_idx  (state_idx),
   .phase_idx  (phase_idx),
   .ale        (ale),
   .psen_n     (psen_n),
   .p0_addr_en (p0_addr_en),
   .p2_addr_en (p2_addr_en),
   .op_latch_en(op_latch_en),
   .fetch2_en  (fetch2_en),
   .pc_inc     (pc_inc),
   .fetch_act  (fetch_act),
   .ext_mode   (ext_mode)
);

// File: tb/mc_strobe_seq_tb_top.sv
module mc_strobe_seq_tb_top;

   localparam int CLK_HALF = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ext_pmem_sel = 1'b0;
   logic       xfer_instr = 1'b0;
   logic [2:0] state_idx;
   logic [0:0] phase_idx;
   logic       ale, psen_n, p0_addr_en, p2_addr_en, op_latch_en, fetch2_en, pc_inc;

   int checks = 0;
   int errors = 0;
   logic prev_ale = 1'b0;
   logic prev_psen = 1'b1;

   always #(CLK_HALF) clk = ~clk;

   mc_strobe_seq dut_i (
      .clk         (clk),
      .rst         (rst),
      .ext_pmem_sel(ext_pmem_sel),
      .xfer_instr  (xfer_instr),
      .state_idx   (state_idx),
      .phase_idx   (phase_idx),
      .ale         (ale),
      .psen_n      (psen_n),
      .p0_addr_en  (p0_addr_en),
      .p2_addr_en  (p2_addr_en),
      .op_latch_en (op_latch_en),
      .fetch2_en   (fetch2_en),
      .pc_inc      (pc_inc)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Leaves the bench on the negedge of S1P1 of the first cycle, reset released.
   task automatic do_reset(bit ext);
      @(negedge clk);
      rst = 1'b1;
      xfer_instr = 1'b0;
      ext_pmem_sel = ext;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk("R1 state after reset", state_idx, 0);
      chk("R1 phase after reset", phase_idx, 0);
      chk("R1 ale after reset", ale, 0);
      chk("R1 psen_n after reset", psen_n, 1);
      chk("R1 p0 after reset", p0_addr_en, 0);
      chk("R1 p2 after reset", p2_addr_en, 0);
      rst = 1'b0;
      prev_ale = ale;
      prev_psen = psen_n;
   endtask

   // Walks one machine cycle tick by tick, from the negedge of its S1P1.
   task automatic run_cycle(string nm, bit fe, bit ex, bit carry,
                            logic [11:0] xmask, int ext_tick, bit ext_val);
      int rises = 0;
      int falls = 0;
      for (int i = 0; i < 12; i++) begin
         bit in_ale, in_ps, in_ad;
         bit e_ale, e_psl, e_p0, e_p2, e_op, e_f2;
         in_ale = (i == 1 || i == 2 || i == 7 || i == 8);
         in_ps  = (i == 4 || i == 5 || i == 6 || i == 10 || i == 11);
         in_ad  = (i != 0);
         e_ale = fe && in_ale;
         e_psl = (fe && ex && in_ps) || (i == 0 && carry);
         e_p0  = fe && ex && in_ale;
         e_p2  = (fe && ex && in_ad) || (i == 0 && carry);
         e_op  = fe && (i == 0);
         e_f2  = fe && (i == 6);
         chk($sformatf("R2 state t%0d %s", i, nm), state_idx, i / 2);
         chk($sformatf("R2 phase t%0d %s", i, nm), phase_idx, i % 2);
         chk($sformatf("R4 ale t%0d %s", i, nm), ale, e_ale);
         chk($sformatf("R5 psen_n t%0d %s", i, nm), psen_n, !e_psl);
         chk($sformatf("R7 p0 t%0d %s", i, nm), p0_addr_en, e_p0);
         chk($sformatf("R7 p2 t%0d %s", i, nm), p2_addr_en, e_p2);
         chk($sformatf("R3 op_latch t%0d %s", i, nm), op_latch_en, e_op);
         chk($sformatf("R3 fetch2 t%0d %s", i, nm), fetch2_en, e_f2);
         chk($sformatf("R3 pc_inc t%0d %s", i, nm), pc_inc, e_op || e_f2);
         if (ale && !prev_ale) rises++;
         if (!psen_n && prev_psen) falls++;
         prev_ale = ale;
         prev_psen = psen_n;
         xfer_instr = xmask[i];
         if (i == ext_tick) ext_pmem_sel = ext_val;
         @(posedge clk);
         @(negedge clk);
      end
      chk($sformatf("R4 ale pulses %s", nm), rises, fe ? 2 : 0);
      chk($sformatf("R5 psen pulses %s", nm), falls, (fe && ex) ? 2 : 0);
   endtask

   task automatic test_external;
      do_reset(1'b1);
      run_cycle("ext c0", 1, 1, 0, 12'h000, -1, 0);
      run_cycle("ext c1", 1, 1, 1, 12'h000, -1, 0);
      run_cycle("ext c2", 1, 1, 1, 12'h000, -1, 0);
   endtask

   task automatic test_internal;
      do_reset(1'b0);
      run_cycle("R6 int c0", 1, 0, 0, 12'h000, -1, 0);
      run_cycle("R6 int c1", 1, 0, 0, 12'h000, -1, 0);
   endtask

   task automatic test_xfer_external;
      do_reset(1'b1);
      run_cycle("R8 ext first", 1, 1, 0, 12'h800, -1, 0);
      run_cycle("R8 ext data", 0, 1, 1, 12'h000, -1, 0);
      run_cycle("R8 ext after", 1, 1, 0, 12'h000, -1, 0);
   endtask

   task automatic test_xfer_internal;
      do_reset(1'b0);
      run_cycle("R8 int first", 1, 0, 0, 12'h800, -1, 0);
      run_cycle("R8 int data", 0, 0, 0, 12'h000, -1, 0);
      run_cycle("R8 int after", 1, 0, 0, 12'h000, -1, 0);
   endtask

   task automatic test_xfer_sampling;
      do_reset(1'b1);
      run_cycle("R9 off-tick", 1, 1, 0, 12'h7FF, -1, 0);
      run_cycle("R9 held", 1, 1, 1, 12'hFFF, -1, 0);
      run_cycle("R9 data held", 0, 1, 1, 12'hFFF, -1, 0);
      run_cycle("R9 no double", 1, 1, 0, 12'h000, -1, 0);
      run_cycle("R9 tail", 1, 1, 1, 12'h000, -1, 0);
   endtask

   task automatic test_mode_switch;
      do_reset(1'b1);
      run_cycle("R10 ext to int", 1, 1, 0, 12'h000, 5, 0);
      run_cycle("R10 int with tail", 1, 0, 1, 12'h000, 3, 1);
      run_cycle("R10 back to ext", 1, 1, 0, 12'h000, -1, 0);
   endtask

   initial begin
      #(CLK_HALF * 2 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      test_external();
      test_internal();
      test_xfer_external();
      test_xfer_internal();
      test_xfer_sampling();
      test_mode_switch();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule